// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address order for one SDRAM read or write burst. A one-cycle start pulse captures a starting column, the read/write direction and the burst settings (length code, sequential or interleaved order, and single-beat writes). From the following cycle the block presents one column address per clock, together with a valid strobe. When the burst ends, a one-cycle done pulse follows.

Fixed-length bursts stay inside an aligned block of columns that is as large as the burst. The high column bits choose the block and never change. The low bits either count upward and wrap, or are the start bits XORed with the beat number. A full-page burst walks the whole row, wraps from the top column to column 0, and keeps going until a terminate arrives. A terminate input cuts any burst short. A new start pulse during a burst abandons that burst.

The control is a three-state machine. `S_IDLE` goes to `S_FIXED` on a start with a fixed length, or to `S_PAGE` on a start with a full-page length. `S_FIXED` returns to `S_IDLE` after its last beat or on a terminate. `S_PAGE` returns to `S_IDLE` only on a terminate. A start in any state reloads the machine into `S_FIXED` or `S_PAGE`.

Top module: `burst_col_seq`

## Requirements
- R1: A start pulse sampled at a clock edge makes `col_vld_o` high in the next cycle, with `col_o` equal to the captured start column.
- R2: Length code 0 gives 1 beat, code 1 gives 2 beats, code 2 gives 4 beats and code 3 gives 8 beats. Beats come one per cycle on consecutive cycles, and `col_vld_o` is low in the cycle after the last beat unless a new burst begins.
- R3: With `interleave_i`=0 the low bits count up from the start and wrap within the aligned block (length 4 starting at 1 gives 1,2,3,0). The bits above the block size keep their start values.
- R4: With `interleave_i`=1 the low bits of beat k equal the start's low bits XOR k (length 8 starting at 5 gives 5,4,7,6,1,0,3,2). The high bits are held.
- R5: Length code 7 with `interleave_i`=0 is a full-page burst. The column increments by one per beat, wraps from 1023 to 0, and the burst continues past 1024 beats until a terminate arrives.
- R6: For a 1-beat burst, `interleave_i` has no effect: the single beat is the start column.
- R7: A start with `is_write_i`=1 and `wr_single_i`=1 produces exactly one beat whatever the length code. A read with `wr_single_i`=1 still uses the programmed length.
- R8: A terminate sampled during a burst, without a start at the same edge, ends the burst: `col_vld_o` is low and `done_o` is high in the next cycle. A terminate while idle has no effect. A start at the same edge takes priority over a terminate.
- R9: `done_o` is a one-cycle pulse in the cycle after a burst's last beat or after its terminate. It appears only after a valid beat. It is high alongside the first beat of a new burst when that burst is started at the edge that completed the previous one.
- R10: A start pulse during a burst abandons that burst with no done pulse. The next cycle shows the new start column as beat 0.
- R11: Length codes 4, 5 and 6, and code 7 with `interleave_i`=1, are reserved. They run as a 1-beat burst and set `cfg_err_o`, which stays high until the next start with a legal code.
- R12: After reset, `col_vld_o`, `done_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a burst |
| start_col_i | input | COL_W | Starting column, captured on start |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| term_i | input | 1 | Ends the burst in progress |
| len_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| interleave_i | input | 1 | 0 for sequential order, 1 for interleaved order |
| wr_single_i | input | 1 | 1 makes writes single-beat |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | High while a beat is presented |
| done_o | output | 1 | One-cycle pulse when a burst ends |
| cfg_err_o | output | 1 | A reserved length code was used at the last start |

## Verification
The same starting columns are run through both orderings and all block sizes. A start in the middle of a block tells a wrap confined to the block apart from a free-running increment. A start near the top of the row shows the full-page wrap to column 0, and a run longer than 1024 beats shows the page mode does not end by itself. Terminates, restarts, back-to-back bursts, single-beat writes and reserved codes are mixed with a long random phase. A behavioural model predicts every cycle, including done pulses that coincide with the first beat of a following burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIXED = 2'd1,
        S_PAGE  = 2'd2
    } seq_state_e;

    localparam logic [2:0] LC_ONE   = 3'd0;
    localparam logic [2:0] LC_TWO   = 3'd1;
    localparam logic [2:0] LC_FOUR  = 3'd2;
    localparam logic [2:0] LC_EIGHT = 3'd3;
    localparam logic [2:0] LC_PAGE  = 3'd7;
endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode #(
    parameter int COL_W = 10
) (
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             wr_single_i,
    output logic [COL_W-1:0] wrap_mask_o,
    output logic             page_o,
    output logic             err_o
);
    import bcs_pkg::*;

    // wrap_mask_o marks the column bits that move within the burst;
    // its value is also the index of the final beat of a fixed burst.
    always_comb begin
        wrap_mask_o = '0;
        page_o      = 1'b0;
        err_o       = 1'b0;
        case (len_code_i)
            LC_ONE:   wrap_mask_o = '0;
            LC_TWO:   wrap_mask_o = COL_W'(1);
            LC_FOUR:  wrap_mask_o = COL_W'(3);
            LC_EIGHT: wrap_mask_o = COL_W'(7);
            LC_PAGE: begin
                if (interleave_i) begin
                    err_o = 1'b1;
                end else begin
                    page_o      = 1'b1;
                    wrap_mask_o = '1;
                end
            end
            default:  err_o = 1'b1;
        endcase
        if (is_write_i && wr_single_i) begin
            wrap_mask_o = '0;
            page_o      = 1'b0;
        end
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] moved;

    always_comb begin
        if (interleave_i) begin
            moved = base_i ^ beat_i;
        end else begin
            moved = base_i + beat_i;
        end
        col_o = (base_i & ~wrap_mask_i) | (moved & wrap_mask_i);
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             is_write_i,
    input logic             term_i,
    input logic [2:0]       len_code_i,
    input logic             interleave_i,
    input logic             wr_single_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_vld_o,
    input logic             done_o,
    input logic             cfg_err_o
);
    logic rsv_code;
    assign rsv_code = (len_code_i[2] && (len_code_i != 3'd7)) ||
                      ((len_code_i == 3'd7) && interleave_i);

    assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_vld_o && col_o == $past(start_col_i)));

    assert_term_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i && col_vld_o) |=> (!col_vld_o && done_o));

    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_vld_o && !start_i) |=> (!col_vld_o && !done_o));

    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(col_vld_o));

    assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && is_write_i && wr_single_i) ##1 !start_i |=> (!col_vld_o && done_o));

    assert_rsv_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rsv_code) |=> cfg_err_o);

    assert_rsv_one_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rsv_code) ##1 !start_i |=> !col_vld_o);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .is_write_i   (is_write_i),
    .term_i       (term_i),
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .wr_single_i  (wr_single_i),
    .col_o        (col_o),
    .col_vld_o    (col_vld_o),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o)
);

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_write_i,
    input  logic             term_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             wr_single_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic             done_o,
    output logic             cfg_err_o
);
    import bcs_pkg::*;

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             il_q, il_d;
    logic             done_q, done_d;
    logic             err_q, err_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_err;
    logic             last_hit;

    bcs_mode_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .is_write_i   (is_write_i),
        .wr_single_i  (wr_single_i),
        .wrap_mask_o  (dec_mask),
        .page_o       (dec_page),
        .err_o        (dec_err)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i       (base_q),
        .beat_i       (beat_q),
        .wrap_mask_i  (mask_q),
        .interleave_i (il_q),
        .col_o        (col_o)
    );

    assign last_hit = (state_q == S_FIXED) && (beat_q == mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        base_d  = base_q;
        mask_d  = mask_q;
        il_d    = il_q;
        err_d   = err_q;
        done_d  = 1'b0;
        if (start_i) begin
            state_d = dec_page ? S_PAGE : S_FIXED;
            beat_d  = '0;
            base_d  = start_col_i;
            mask_d  = dec_mask;
            il_d    = interleave_i;
            err_d   = dec_err;
            done_d  = last_hit;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                end
                S_FIXED: begin
                    if (term_i || last_hit) begin
                        state_d = S_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
                S_PAGE: begin
                    if (term_i) begin
                        state_d = S_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            il_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            mask_q  <= mask_d;
            il_q    <= il_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        col_vld_o = (state_q != S_IDLE);
        done_o    = done_q;
        cfg_err_o = err_q;
    end
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
    localparam int COLS = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic       is_write_i = 1'b0;
    logic       term_i = 1'b0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       wr_single_i = 1'b0;
    logic [9:0] col_o;
    logic       col_vld_o;
    logic       done_o;
    logic       cfg_err_o;

    int total = 0;
    int bad = 0;
    string cur_req = "R12";
    bit finished = 0;

    // behavioural reference state
    int m_busy = 0, m_beat = 0, m_len = 1, m_full = 0, m_il = 0;
    int m_start = 0, m_done = 0, m_err = 0;

    always #10 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .is_write_i(is_write_i), .term_i(term_i), .len_code_i(len_code_i),
        .interleave_i(interleave_i), .wr_single_i(wr_single_i),
        .col_o(col_o), .col_vld_o(col_vld_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_col();
        int base, off;
        if (m_full != 0) return (m_start + m_beat) % COLS;
        base = m_start - (m_start % m_len);
        off  = m_start % m_len;
        if (m_il != 0) return base + (off ^ m_beat);
        return base + ((off + m_beat) % m_len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_beat = 0;
        end else begin
            m_done = 0;
            if (start_i) begin
                if (m_busy != 0 && m_full == 0 && m_beat == m_len - 1) m_done = 1;
                m_err = 0; m_full = 0;
                case (int'(len_code_i))
                    0: m_len = 1;
                    1: m_len = 2;
                    2: m_len = 4;
                    3: m_len = 8;
                    7: begin
                        m_len = 1;
                        if (interleave_i) m_err = 1; else m_full = 1;
                    end
                    default: begin m_len = 1; m_err = 1; end
                endcase
                if (is_write_i && wr_single_i) begin m_len = 1; m_full = 0; end
                m_busy = 1; m_beat = 0; m_start = int'(start_col_i); m_il = int'(interleave_i);
            end else if (m_busy != 0) begin
                if (term_i || (m_full == 0 && m_beat == m_len - 1)) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_beat++;
                end
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, int'(col_vld_o), m_busy);
            if (m_busy != 0) chk(cur_req, int'(col_o), model_col());
            chk(cur_req, int'(done_o), m_done);
            chk(cur_req, int'(cfg_err_o), m_err);
        end
    end

    task automatic go(input int col, input int code, input bit il, input bit wr, input bit single);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 10'(col); len_code_i = 3'(code);
        interleave_i = il; is_write_i = wr; wr_single_i = single;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_term();
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R12 reset state
        idle(3);
        chk("R12", int'(col_vld_o), 0);
        chk("R12", int'(done_o), 0);
        chk("R12", int'(cfg_err_o), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R12", int'(col_vld_o), 0);

        // R1 / R2 each length, sequential
        cur_req = "R2";
        for (int c = 0; c < 4; c++) begin
            go(10'h3F5, c, 0, 0, 0);
            chk("R1", int'(col_o), 10'h3F5);
            idle(10);
        end

        // R3 explicit sequence 1,2,3,0 (upper bits 0x1A0 held)
        cur_req = "R3";
        go(10'h1A1, 2, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R3", int'(col_o), 10'h1A0 + ((1 + i) % 4));
            @(negedge clk);
        end
        chk("R3", int'(col_vld_o), 0);
        idle(3);

        // R4 explicit interleaved 5,4,7,6,1,0,3,2
        cur_req = "R4";
        go(10'h2C5, 3, 1, 0, 0);
        for (int i = 0; i < 8; i++) begin
            chk("R4", int'(col_o), 10'h2C0 + (5 ^ i));
            @(negedge clk);
        end
        go(10'h2B6, 2, 1, 0, 0);
        idle(6);
        go(10'h0FF, 1, 1, 0, 0);
        idle(4);

        // R5 full page wrap and long run
        cur_req = "R5";
        go(1020, 7, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            chk("R5", int'(col_o), (1020 + i) % COLS);
            @(negedge clk);
        end
        idle(1100);
        chk("R5", int'(col_vld_o), 1);
        pulse_term();
        chk("R5", int'(col_vld_o), 0);
        chk("R5", int'(done_o), 1);
        idle(3);

        // R6 length 1 ignores type
        cur_req = "R6";
        go(10'h133, 0, 1, 0, 0);
        chk("R6", int'(col_o), 10'h133);
        @(negedge clk);
        chk("R6", int'(col_vld_o), 0);
        idle(2);

        // R7 single-beat writes vs reads
        cur_req = "R7";
        go(10'h044, 3, 0, 1, 1);
        @(negedge clk);
        chk("R7", int'(col_vld_o), 0);
        go(10'h044, 3, 0, 0, 1);
        idle(10);
        go(10'h044, 7, 0, 1, 1);
        @(negedge clk);
        chk("R7", int'(col_vld_o), 0);
        go(10'h044, 3, 0, 1, 0);
        idle(10);

        // R8 terminate mid-burst, while idle, and against a start
        cur_req = "R8";
        go(10'h210, 3, 0, 0, 0);
        idle(2);
        pulse_term();
        chk("R8", int'(col_vld_o), 0);
        idle(2);
        pulse_term();
        chk("R8", int'(done_o), 0);
        go(10'h210, 3, 0, 0, 0);
        @(negedge clk);
        term_i = 1'b1;
        start_i = 1'b1; start_col_i = 10'h077; len_code_i = 3'd2;
        @(negedge clk);
        term_i = 1'b0; start_i = 1'b0;
        chk("R8", int'(col_o), 10'h077);
        chk("R8", int'(done_o), 0);
        idle(6);

        // R9 back-to-back bursts
        cur_req = "R9";
        go(10'h300, 1, 0, 0, 0);
        go(10'h305, 0, 0, 0, 0);
        chk("R9", int'(done_o), 1);
        go(10'h306, 1, 0, 0, 0);
        idle(4);

        // R10 restart abandons burst
        cur_req = "R10";
        go(10'h100, 3, 0, 0, 0);
        idle(2);
        go(10'h1F3, 2, 1, 0, 0);
        chk("R10", int'(col_o), 10'h1F3);
        chk("R10", int'(done_o), 0);
        idle(6);

        // R11 reserved codes
        cur_req = "R11";
        for (int c = 4; c < 7; c++) begin
            go(10'h0A3, c, 0, 0, 0);
            @(negedge clk);
            chk("R11", int'(col_vld_o), 0);
            chk("R11", int'(cfg_err_o), 1);
        end
        go(10'h0A3, 7, 1, 0, 0);
        idle(3);
        chk("R11", int'(cfg_err_o), 1);
        go(10'h0A3, 2, 0, 0, 0);
        chk("R11", int'(cfg_err_o), 0);
        idle(6);

        // random mix
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start_i      = ($urandom_range(0, 7) == 0);
            term_i       = ($urandom_range(0, 15) == 0);
            start_col_i  = 10'($urandom_range(0, 1023));
            len_code_i   = 3'($urandom_range(0, 7));
            interleave_i = 1'($urandom_range(0, 1));
            is_write_i   = 1'($urandom_range(0, 1));
            wr_single_i  = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        idle(20);
        finish_run();
    end
endmodule